// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

The block gathers up to 128 peripheral interrupt lines for a small processor. Each line has an enable bit, a pending bit and a 3-bit urgency level. A pending bit is set by a rising edge on the line, by a bus write, or by a software trigger that names a line by its number. It is cleared by a bus write, or by the processor when it acknowledges the vector that is currently presented.

Every cycle an arbiter chooses, among the lines that are both pending and enabled, the one with the numerically smallest level. A tie goes to the lower line number. The result is registered and presented as an exception number (line number plus 16) together with its level.

Software reaches the state through a plain 32-bit word-addressed register bus. Writes take effect on the clock edge where `reg_we` is high. Read data is combinational from the current state and the address.

Top module: `vic_core`

## Requirements
- R1: After reset every enable, pending and level field is zero, `vec_valid` is 0, and every register reads 0.
- R2: Line n has its enable bit at bit n%32 of bank n/32. Words 0x00-0x03 are the set-enable banks and words 0x04-0x07 are the clear-enable banks. In a set bank a 1 sets the bit and in a clear bank a 1 clears it; a 0 has no effect in either. Both words of a bank pair read back the current enable bits.
- R3: The pending bits use the same bank layout. Words 0x08-0x0B set them and words 0x0C-0x0F clear them, with the same write-one and read-back rules as R2.
- R4: The level of line n sits in word 0x20+n/4, byte lane n%4. Only bits [7:5] of each lane are stored. Bits [4:0] read back as zero. A write to one of these words sets all four lanes.
- R5: A 0-to-1 transition on `irq_lines[n]` sets pending bit n. A line that stays high does not set the bit again once it has been cleared.
- R6: Writing k to word 0x10 sets pending bit k when k < 128. A value k >= 128 changes nothing. The word reads back as 0.
- R7: `vec_valid` is 1 exactly when at least one line is both pending and enabled. `vec_num` then carries line+16 and `vec_prio` carries that line's level. These outputs change one cycle after the state change that causes them.
- R8: The presented line has the smallest level among eligible lines. Among lines with equal level, the lowest line number is presented.
- R9: `ack` while `vec_valid` is 1 clears the pending bit of the presented line on that edge. If a new set event (edge, set-pending write or trigger) for the same line lands on that edge, the bit stays set.
- R10: A pending line that is disabled is not presented but stays pending, and it is presented once it is enabled. Clearing a pending bit before the line is acknowledged discards the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_lines | input | 128 | Peripheral interrupt lines |
| ack | input | 1 | Processor takes the presented vector |
| vec_valid | output | 1 | A vector is presented |
| vec_num | output | 8 | Exception number of the presented line |
| vec_prio | output | 3 | Level of the presented line |

## Verification
An acknowledge and a fresh rising edge on the same line can arrive on the same clock edge. That would wipe out a new request if the clear won. The bench provokes this by raising the line of the presented vector in the same cycle as `ack`. It judges the outcome by checking that the same vector is still presented afterwards, and that a second acknowledge with no new edge then empties the controller. The bench also changes a level while two requests are pending and checks that the presented vector keeps its old value for exactly one cycle before it switches.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int DATA_W  = 32;
    localparam int LANE_W  = 8;
    localparam int VEC_OFS = 16;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_SET_EN,
        WIN_CLR_EN,
        WIN_SET_PD,
        WIN_CLR_PD,
        WIN_TRIG,
        WIN_PRIO
    } win_e;
endpackage

// File: rtl/vic_decode.sv
module vic_decode
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 128,
    parameter int ADDR_W  = 7,
    localparam int NPW    = NUM_IRQ / 4,
    localparam int IDX_W  = (NPW > 1) ? $clog2(NPW) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output win_e              win,
    output logic [IDX_W-1:0]  idx
);
    localparam int NB        = NUM_IRQ / 32;
    localparam int SET_EN_B  = 0;
    localparam int CLR_EN_B  = NB;
    localparam int SET_PD_B  = 2 * NB;
    localparam int CLR_PD_B  = 3 * NB;
    localparam int TRIG_A    = 4 * NB;
    localparam int PRIO_B    = 8 * NB;

    always_comb begin
        int a;
        a   = int'(addr);
        win = WIN_NONE;
        idx = '0;
        if (a < CLR_EN_B) begin
            win = WIN_SET_EN;
            idx = IDX_W'(a - SET_EN_B);
        end else if (a < SET_PD_B) begin
            win = WIN_CLR_EN;
            idx = IDX_W'(a - CLR_EN_B);
        end else if (a < CLR_PD_B) begin
            win = WIN_SET_PD;
            idx = IDX_W'(a - SET_PD_B);
        end else if (a < TRIG_A) begin
            win = WIN_CLR_PD;
            idx = IDX_W'(a - CLR_PD_B);
        end else if (a == TRIG_A) begin
            win = WIN_TRIG;
        end else if (a >= PRIO_B && a < PRIO_B + NPW) begin
            win = WIN_PRIO;
            idx = IDX_W'(a - PRIO_B);
        end
    end
endmodule

// File: rtl/vic_state.sv
module vic_state
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 128,
    parameter int PRIO_W  = 3,
    localparam int NPW    = NUM_IRQ / 4,
    localparam int IDX_W  = (NPW > 1) ? $clog2(NPW) : 1,
    localparam int LINE_W = $clog2(NUM_IRQ)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  win_e                          win,
    input  logic [IDX_W-1:0]              idx,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [NUM_IRQ-1:0]            irq_lines,
    input  logic                          ack_take,
    input  logic [LINE_W-1:0]             ack_line,
    output logic [NUM_IRQ-1:0]            en_o,
    output logic [NUM_IRQ-1:0]            pend_o,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_o,
    output logic [DATA_W-1:0]             rdata
);
    localparam int LOW_W = LANE_W - PRIO_W;

    typedef struct packed {
        logic [NUM_IRQ-1:0]             en;
        logic [NUM_IRQ-1:0]             pend;
        logic [NUM_IRQ-1:0]             prev;
        logic [NUM_IRQ-1:0][PRIO_W-1:0] prio;
    } st_t;

    st_t st_d, st_q;
    logic [NUM_IRQ-1:0] set_v, clr_v;

    always_comb begin
        int bi;
        bi    = int'(idx);
        st_d  = st_q;
        set_v = irq_lines & ~st_q.prev;
        clr_v = '0;
        st_d.prev = irq_lines;
        if (we) begin
            case (win)
                WIN_SET_EN: st_d.en[DATA_W*bi +: DATA_W] = st_q.en[DATA_W*bi +: DATA_W] | wdata;
                WIN_CLR_EN: st_d.en[DATA_W*bi +: DATA_W] = st_q.en[DATA_W*bi +: DATA_W] & ~wdata;
                WIN_SET_PD: set_v[DATA_W*bi +: DATA_W]   = set_v[DATA_W*bi +: DATA_W] | wdata;
                WIN_CLR_PD: clr_v[DATA_W*bi +: DATA_W]   = wdata;
                WIN_TRIG: begin
                    if (wdata < DATA_W'(NUM_IRQ))
                        set_v[wdata[LINE_W-1:0]] = 1'b1;
                end
                WIN_PRIO: begin
                    for (int l = 0; l < 4; l++)
                        st_d.prio[4*bi + l] = wdata[LANE_W*l + LOW_W +: PRIO_W];
                end
                default: ;
            endcase
        end
        if (ack_take)
            clr_v[ack_line] = 1'b1;
        // new set events win over clears landing on the same edge
        st_d.pend = (st_q.pend & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        int bi;
        bi    = int'(idx);
        rdata = '0;
        case (win)
            WIN_SET_EN, WIN_CLR_EN: rdata = st_q.en[DATA_W*bi +: DATA_W];
            WIN_SET_PD, WIN_CLR_PD: rdata = st_q.pend[DATA_W*bi +: DATA_W];
            WIN_PRIO: begin
                for (int l = 0; l < 4; l++)
                    rdata[LANE_W*l + LOW_W +: PRIO_W] = st_q.prio[4*bi + l];
            end
            default: rdata = '0;
        endcase
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign prio_o = st_q.prio;

    // R2: a set-enable write never drops an enable bit
    a_r2_set_never_clears: assert property (@(posedge clk) disable iff (rst)
        (we && win == WIN_SET_EN) |=> ((st_q.en & $past(st_q.en)) == $past(st_q.en)));

    // R2: a clear-enable write never raises an enable bit
    a_r2_clear_never_sets: assert property (@(posedge clk) disable iff (rst)
        (we && win == WIN_CLR_EN) |=> ((st_q.en & ~$past(st_q.en)) == '0));

    // R4: levels move only on a level-window write
    a_r4_prio_stable: assert property (@(posedge clk) disable iff (rst)
        !(we && win == WIN_PRIO) |=> $stable(st_q.prio));
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
    parameter int NUM_IRQ = 128,
    parameter int PRIO_W  = 3,
    localparam int LINE_W = $clog2(NUM_IRQ)
) (
    input  logic [NUM_IRQ-1:0]             elig,
    input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio,
    output logic                           win_valid,
    output logic [LINE_W-1:0]              win_line,
    output logic [PRIO_W-1:0]              win_prio
);
    // scan from the top down; "<=" lets a lower number take a tie
    always_comb begin
        win_valid = 1'b0;
        win_line  = '0;
        win_prio  = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (elig[i] && (!win_valid || prio[i] <= win_prio)) begin
                win_valid = 1'b1;
                win_line  = LINE_W'(i);
                win_prio  = prio[i];
            end
        end
    end

    always_comb begin
        a_r7_valid_when_any: assert (win_valid == (|elig));
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (win_valid && elig[i]) begin
                a_r8_most_urgent: assert (prio[i] > win_prio ||
                    (prio[i] == win_prio && LINE_W'(i) >= win_line));
            end
        end
    end
endmodule

// File: rtl/vic_core.sv
module vic_core
    import vic_pkg::*;
#(
    parameter int NUM_IRQ = 128,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 7,
    localparam int LINE_W = $clog2(NUM_IRQ),
    localparam int VEC_W  = $clog2(NUM_IRQ + VEC_OFS),
    localparam int NPW    = NUM_IRQ / 4,
    localparam int IDX_W  = (NPW > 1) ? $clog2(NPW) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               ack,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_num,
    output logic [PRIO_W-1:0]  vec_prio
);
    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        logic [VEC_W-1:0]  num;
        logic [PRIO_W-1:0] prio;
    } out_t;

    win_e                           win;
    logic [IDX_W-1:0]               idx;
    logic [NUM_IRQ-1:0]             en_w, pend_w, elig_w;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_w;
    logic                           arb_valid;
    logic [LINE_W-1:0]              arb_line;
    logic [PRIO_W-1:0]              arb_prio;
    logic                           ack_take;
    logic [NUM_IRQ-1:0]             vec_onehot;
    out_t                           out_d, out_q;

    vic_decode #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_decode (
        .addr (reg_addr),
        .win  (win),
        .idx  (idx)
    );

    vic_state #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_state (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .win       (win),
        .idx       (idx),
        .wdata     (reg_wdata),
        .irq_lines (irq_lines),
        .ack_take  (ack_take),
        .ack_line  (out_q.line),
        .en_o      (en_w),
        .pend_o    (pend_w),
        .prio_o    (prio_w),
        .rdata     (reg_rdata)
    );

    assign elig_w = en_w & pend_w;

    vic_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
        .elig      (elig_w),
        .prio      (prio_w),
        .win_valid (arb_valid),
        .win_line  (arb_line),
        .win_prio  (arb_prio)
    );

    assign ack_take = ack && out_q.valid;

    always_comb begin
        out_d       = '0;
        out_d.valid = arb_valid;
        if (arb_valid) begin
            out_d.line = arb_line;
            out_d.num  = VEC_W'(arb_line) + VEC_W'(VEC_OFS);
            out_d.prio = arb_prio;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign vec_valid  = out_q.valid;
    assign vec_num    = out_q.num;
    assign vec_prio   = out_q.prio;
    assign vec_onehot = NUM_IRQ'(1) << out_q.line;

    // R7: a presented line was pending and enabled one cycle earlier
    a_r7_presented_eligible: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (|($past(elig_w) & vec_onehot)));

    // R9: an acknowledge with no competing set event drops the taken line
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack && vec_valid && !reg_we && irq_lines == $past(irq_lines))
        |=> ((pend_w & $past(vec_onehot)) == '0));
endmodule

// File: tb/vic_core_tb.sv
`timescale 1ns/1ps
module vic_core_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         reg_we;
    logic [6:0]   reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata;
    logic [127:0] irq_lines;
    logic         ack;
    logic         vec_valid;
    logic [7:0]   vec_num;
    logic [2:0]   vec_prio;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vic_core u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_lines(irq_lines),
        .ack(ack), .vec_valid(vec_valid), .vec_num(vec_num), .vec_prio(vec_prio)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_vec(input string tag, input logic v, input logic [7:0] n, input logic [2:0] p);
        chk({tag, " valid"}, 32'(vec_valid), 32'(v));
        if (v) begin
            chk({tag, " num"}, 32'(vec_num), 32'(n));
            chk({tag, " prio"}, 32'(vec_prio), 32'(p));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk_vec("R1 reset vector", 1'b0, 8'd0, 3'd0);
        rd(7'h00, d); chk("R1 enable reads 0", d, 32'h0);
        rd(7'h0B, d); chk("R1 pending reads 0", d, 32'h0);
        rd(7'h3F, d); chk("R1 level reads 0", d, 32'h0);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(7'h01, 32'h0000_00F0);
        rd(7'h01, d); chk("R2 set bank read", d, 32'h0000_00F0);
        rd(7'h05, d); chk("R2 clear bank read", d, 32'h0000_00F0);
        wr(7'h01, 32'h0000_0001);
        rd(7'h01, d); chk("R2 set zeros no effect", d, 32'h0000_00F1);
        wr(7'h05, 32'h0000_0030);
        rd(7'h01, d); chk("R2 clear ones", d, 32'h0000_00C1);
        wr(7'h05, 32'h0);
        rd(7'h05, d); chk("R2 clear zeros no effect", d, 32'h0000_00C1);
        rd(7'h00, d); chk("R2 other bank untouched", d, 32'h0);
        wr(7'h05, 32'hFFFF_FFFF);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(7'h0A, 32'h8000_0101);
        rd(7'h0A, d); chk("R3 set pending", d, 32'h8000_0101);
        wr(7'h0A, 32'h0);
        rd(7'h0E, d); chk("R3 set zeros no effect", d, 32'h8000_0101);
        wr(7'h0E, 32'h0000_0100);
        rd(7'h0A, d); chk("R3 clear one bit", d, 32'h8000_0001);
        step();
        chk_vec("R10 pending but disabled", 1'b0, 8'd0, 3'd0);
        wr(7'h0E, 32'hFFFF_FFFF);
        rd(7'h0E, d); chk("R3 clear all", d, 32'h0);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(7'h21, 32'hFFFF_FFFF);
        rd(7'h21, d); chk("R4 only top bits kept", d, 32'hE0E0_E0E0);
        wr(7'h21, 32'h1234_5678);
        rd(7'h21, d); chk("R4 lanes", d, 32'h0020_4060);
        rd(7'h22, d); chk("R4 neighbour word", d, 32'h0);
        wr(7'h21, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        wr(7'h00, 32'h0000_0008);
        @(negedge clk); irq_lines[3] = 1'b1;
        step(); step();
        chk_vec("R5 rising edge presents line 3", 1'b1, 8'd19, 3'd0);
        wr(7'h0C, 32'h0000_0008);
        step(); step();
        chk_vec("R5 held line no repend", 1'b0, 8'd0, 3'd0);
        rd(7'h08, d); chk("R5 pending after held", d, 32'h0);
        irq_lines[3] = 1'b0;
        wr(7'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_trigger();
        logic [31:0] d, acc;
        wr(7'h03, 32'h0000_0010);
        wr(7'h10, 32'd100);
        rd(7'h0B, d); chk("R6 trigger sets line 100", d, 32'h0000_0010);
        rd(7'h10, d); chk("R6 trigger reads 0", d, 32'h0);
        step();
        chk_vec("R6 triggered vector", 1'b1, 8'd116, 3'd0);
        wr(7'h0F, 32'hFFFF_FFFF);
        wr(7'h10, 32'd200);
        acc = '0;
        for (int b = 0; b < 4; b++) begin
            rd(7'(8 + b), d);
            acc = acc | d;
        end
        chk("R6 out of range ignored", acc, 32'h0);
        wr(7'h07, 32'hFFFF_FFFF);
    endtask

    task automatic t_arbitration();
        wr(7'h00, 32'h0000_0020);
        wr(7'h01, 32'h0000_0100);
        wr(7'h02, 32'h0000_0040);
        wr(7'h21, 32'h0000_C000);
        wr(7'h2A, 32'h0000_0040);
        wr(7'h31, 32'h0040_0000);
        wr(7'h08, 32'h0000_0020);
        wr(7'h09, 32'h0000_0100);
        wr(7'h0A, 32'h0000_0040);
        step();
        chk_vec("R8 tie goes to lower line", 1'b1, 8'd56, 3'd2);
        wr(7'h31, 32'h0020_0000);
        chk_vec("R7 one cycle latency old", 1'b1, 8'd56, 3'd2);
        step();
        chk_vec("R8 more urgent wins", 1'b1, 8'd86, 3'd1);
        wr(7'h0E, 32'h0000_0040);
        wr(7'h0D, 32'h0000_0100);
        step();
        chk_vec("R7 last remaining", 1'b1, 8'd21, 3'd6);
        wr(7'h0C, 32'h0000_0020);
        step();
        chk_vec("R7 none eligible", 1'b0, 8'd0, 3'd0);
        for (int b = 0; b < 4; b++) wr(7'(4 + b), 32'hFFFF_FFFF);
        wr(7'h21, 32'h0); wr(7'h2A, 32'h0); wr(7'h31, 32'h0);
    endtask

    task automatic t_ack();
        logic [31:0] d;
        wr(7'h00, 32'h0000_0C00);
        wr(7'h08, 32'h0000_0C00);
        step();
        chk_vec("R9 first presented", 1'b1, 8'd26, 3'd0);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        step();
        chk_vec("R9 ack moves to next", 1'b1, 8'd27, 3'd0);
        @(negedge clk); ack = 1'b1; irq_lines[11] = 1'b1;
        @(negedge clk); ack = 1'b0;
        step();
        chk_vec("R9 edge beats ack", 1'b1, 8'd27, 3'd0);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        step();
        chk_vec("R9 second ack empties", 1'b0, 8'd0, 3'd0);
        rd(7'h08, d); chk("R9 pending cleared", d, 32'h0);
        irq_lines[11] = 1'b0;
        wr(7'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_discard();
        logic [31:0] d;
        wr(7'h08, 32'h0010_0000);
        step();
        chk_vec("R10 disabled not presented", 1'b0, 8'd0, 3'd0);
        wr(7'h00, 32'h0010_0000);
        step();
        chk_vec("R10 presented once enabled", 1'b1, 8'd36, 3'd0);
        wr(7'h04, 32'h0010_0000);
        step();
        chk_vec("R10 disabled again", 1'b0, 8'd0, 3'd0);
        rd(7'h08, d); chk("R10 still pending", d, 32'h0010_0000);
        wr(7'h0C, 32'h0010_0000);
        wr(7'h00, 32'h0010_0000);
        step();
        chk_vec("R10 discarded request", 1'b0, 8'd0, 3'd0);
        wr(7'h04, 32'hFFFF_FFFF);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_lines = '0; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_enable();
        t_pending();
        t_priority();
        t_edge();
        t_trigger();
        t_arbitration();
        t_ack();
        t_discard();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule